// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block is the configuration front end of a clock synthesizer. It holds the feedback divider value (9 bits), the output divider select (2 bits) and a 2-bit test selector. The downstream divider counters, the oscillator and the loop are outside it. The active values can come from parallel pins or from a three-wire serial port made of a serial clock, serial data and a serial load strobe. The three serial signals are sampled in one system clock domain. Their edges are seen as synchronous events that are one clock wide.

When the active-low parallel-load pin is low, the divider registers follow the pins. When that pin rises, they keep the last values they followed. When the pin is high, the serial port owns the registers. Frames shift in MSB first. A rising serial load commits the frame. Shifting while the load strobe stays high updates the registers on every shift. The test selector picks what drives the test pin: a constant low, the oldest bit in the shift register, the feedback divider output, or the synthesized clock. The output divider select is also decoded into its divide ratio.

Top module: `syncfg_loader`

## Requirements
- R1: While par_load_n is low, m_val and n_sel take the values of m_pins and n_pins from the previous clock, one clock after sampling.
- R2: While par_load_n is low, test_out is 0, whatever the test selector and the mdiv_in and fout_in inputs are.
- R3: While par_load_n is high and no serial clock or serial load edge occurs, m_val and n_sel hold. After a rise of par_load_n they keep the values of the last low cycle, even if the pins change.
- R4: With par_load_n high, every sampled rise of ser_clk shifts ser_dat into bit 0 of a 14-bit shift register. The frame order, first bit in, is: select bit 1, select bit 0, one null bit, N1, N0, M8 down to M0. So after 14 shifts, bits [13:12] hold the selector, bit 11 holds the null bit, bits [10:9] hold N and bits [8:0] hold M. Shifting with ser_load low leaves m_val and n_sel unchanged.
- R5: A sampled rise of ser_load (with par_load_n high) copies the selector, N and M fields of the shift register into the active registers. The null bit has no effect.
- R6: After ser_load falls, further shifts with ser_load low leave m_val, n_sel and the selector unchanged.
- R7: While ser_load is high, every serial clock rise updates m_val, n_sel and the selector from the shift register contents that include the bit just shifted.
- R8: With par_load_n high, the selector drives test_out as follows. 00 gives 0. 01 gives shift register bit 13, which is the oldest bit. 10 gives mdiv_in. 11 gives fout_in.
- R9: div_ratio decodes n_sel as 00→2, 01→4, 10→8 and 11→16.
- R10: mreset is passed to div_clr. It does not alter m_val, n_sel or the selector.
- R11: rst (synchronous, active high) clears the shift register, the selector, m_val and n_sel. After release, while par_load_n is low, the registers follow the pins again.
- R12: Serial clock and serial load activity while par_load_n is low changes neither the active registers nor the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| par_load_n | input | 1 | Active-low parallel load: low = follow pins, high = hold/serial |
| m_pins | input | 9 | Parallel feedback divider value |
| n_pins | input | 2 | Parallel output divider select |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe, sampled |
| mreset | input | 1 | Master reset for the downstream dividers |
| mdiv_in | input | 1 | Feedback divider output, for the test mux |
| fout_in | input | 1 | Synthesized clock, for the test mux |
| m_val | output | 9 | Active feedback divider value |
| n_sel | output | 2 | Active output divider select |
| div_ratio | output | 5 | Decoded output divide ratio |
| test_out | output | 1 | Test pin |
| div_clr | output | 1 | Clear for the downstream dividers |

## Verification
The assertions check several properties on every cycle. In parallel mode, the pins are followed one clock later and the test pin is held low. With the port idle in serial mode, the divider registers hold. The decoded ratio always has exactly one bit set. The bench scenarios are needed for what depends on a frame's history: the bit order of a frame, seen through the test pin's view of the oldest shift bit; the commit on the load edge; pass-through while the strobe is high; that the null bit is ignored; and that the selector survives master reset but is cleared by power-on reset.

// File: rtl/syncfg_pkg.sv
package syncfg_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int NULL_W  = 1;
    localparam int FRAME_W = T_W + NULL_W + N_W + M_W;
    localparam int RATIO_W = (1 << N_W) + 1;

    typedef enum logic [T_W-1:0] {
        TSEL_LOW   = 2'b00,
        TSEL_SHIFT = 2'b01,
        TSEL_MDIV  = 2'b10,
        TSEL_FOUT  = 2'b11
    } tsel_e;

    typedef struct packed {
        tsel_e            t;
        logic [N_W-1:0]   n;
        logic [M_W-1:0]   m;
    } cfg_t;

    // Unpack a frame; the null slot sits between the selector and N.
    function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
        cfg_t c;
        c.t = tsel_e'(f[FRAME_W-1 -: T_W]);
        c.n = f[M_W+N_W-1 -: N_W];
        c.m = f[M_W-1:0];
        return c;
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [N_W-1:0] n);
        return RATIO_W'(2) << n;
    endfunction
endpackage

// File: rtl/syncfg_edge.sv
module syncfg_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= din;
    end

    for (genvar i = 0; i < W; i++) begin : g_rise
        assign rise[i] = din[i] & ~prev_q[i];
    end
endmodule

// File: rtl/syncfg_shreg.sv
module syncfg_shreg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);
    assign nxt = shift_en ? {q[W-2:0], din} : q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/syncfg_testmux.sv
module syncfg_testmux
    import syncfg_pkg::*;
(
    input  logic  par_mode,
    input  tsel_e sel,
    input  logic  ser_bit,
    input  logic  mdiv,
    input  logic  fout,
    output logic  out
);
    always_comb begin
        out = 1'b0;
        if (!par_mode) begin
            unique case (sel)
                TSEL_LOW:   out = 1'b0;
                TSEL_SHIFT: out = ser_bit;
                TSEL_MDIV:  out = mdiv;
                TSEL_FOUT:  out = fout;
                default:    out = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/syncfg_loader.sv
module syncfg_loader
    import syncfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               par_load_n,
    input  logic [M_W-1:0]     m_pins,
    input  logic [N_W-1:0]     n_pins,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_load,
    input  logic               mreset,
    input  logic               mdiv_in,
    input  logic               fout_in,
    output logic [M_W-1:0]     m_val,
    output logic [N_W-1:0]     n_sel,
    output logic [RATIO_W-1:0] div_ratio,
    output logic               test_out,
    output logic               div_clr
);
    localparam int EV_CLK  = 0;
    localparam int EV_LOAD = 1;

    logic [1:0]         ev_rise;
    logic [FRAME_W-1:0] sreg_q;
    logic [FRAME_W-1:0] sreg_nxt;
    logic               shift_en;
    logic               commit;
    cfg_t               cfg_q;

    syncfg_edge #(.W(2)) u_edge (
        .clk  (clk),
        .din  ({ser_load, ser_clk}),
        .rise (ev_rise)
    );

    assign shift_en = par_load_n & ev_rise[EV_CLK];
    // Commit on the strobe's rising edge, or on every shift while it stays high.
    assign commit   = par_load_n & (ev_rise[EV_LOAD] | (ser_load & ev_rise[EV_CLK]));

    syncfg_shreg #(.W(FRAME_W)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (ser_dat),
        .q        (sreg_q),
        .nxt      (sreg_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!par_load_n) begin
            cfg_q.m <= m_pins;
            cfg_q.n <= n_pins;
        end else if (commit) begin
            cfg_q <= frame_to_cfg(sreg_nxt);
        end
    end

    syncfg_testmux u_tmux (
        .par_mode (~par_load_n),
        .sel      (cfg_q.t),
        .ser_bit  (sreg_q[FRAME_W-1]),
        .mdiv     (mdiv_in),
        .fout     (fout_in),
        .out      (test_out)
    );

    assign m_val     = cfg_q.m;
    assign n_sel     = cfg_q.n;
    assign div_ratio = ratio_of(cfg_q.n);
    assign div_clr   = mreset;
endmodule

// File: rtl/syncfg_checks.sv
module syncfg_checks
    import syncfg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               par_load_n,
    input logic [M_W-1:0]     m_pins,
    input logic [N_W-1:0]     n_pins,
    input logic               ser_clk,
    input logic               ser_load,
    input logic [M_W-1:0]     m_val,
    input logic [N_W-1:0]     n_sel,
    input logic [RATIO_W-1:0] div_ratio,
    input logic               test_out
);
    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !par_load_n |=> (m_val == $past(m_pins) && n_sel == $past(n_pins))); // R1

    AST_PAR_TEST_LOW: assert property (@(posedge clk) disable iff (rst)
        !par_load_n |-> !test_out); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (par_load_n && $stable(ser_clk) && $stable(ser_load))
        |=> ($stable(m_val) && $stable(n_sel))); // R3

    AST_RATIO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        ($countones(div_ratio) == 1 && !div_ratio[0])); // R9
endmodule

bind syncfg_loader syncfg_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .par_load_n (par_load_n),
    .m_pins     (m_pins),
    .n_pins     (n_pins),
    .ser_clk    (ser_clk),
    .ser_load   (ser_load),
    .m_val      (m_val),
    .n_sel      (n_sel),
    .div_ratio  (div_ratio),
    .test_out   (test_out)
);

// File: tb/sim_syncfg_loader.sv
module sim_syncfg_loader;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst, par_load_n, ser_clk, ser_dat, ser_load, mreset, mdiv_in, fout_in;
    logic [8:0] m_pins;
    logic [1:0] n_pins;
    logic [8:0] m_val;
    logic [1:0] n_sel;
    logic [4:0] div_ratio;
    logic       test_out, div_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [13:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    syncfg_loader u0 (
        .clk(clk), .rst(rst), .par_load_n(par_load_n), .m_pins(m_pins), .n_pins(n_pins),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load), .mreset(mreset),
        .mdiv_in(mdiv_in), .fout_in(fout_in), .m_val(m_val), .n_sel(n_sel),
        .div_ratio(div_ratio), .test_out(test_out), .div_clr(div_clr)
    );

    // {m_pins, n_pins, expected ratio}
    localparam logic [15:0] VEC [6] = '{
        {9'd10,  2'd0, 5'd2},
        {9'd28,  2'd1, 5'd4},
        {9'h1FF, 2'd2, 5'd8},
        {9'h000, 2'd3, 5'd16},
        {9'h155, 2'd1, 5'd4},
        {9'h0AA, 2'd2, 5'd8}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] frame(input logic [1:0] t, input logic nul,
                                          input logic [1:0] n, input logic [8:0] m);
        return {t, nul, n, m};
    endfunction

    // Shift bits MSB first; with ser_load high, check pass-through per shift (R7).
    task automatic send(input logic [13:0] f, input int nbits, input bit pass_chk);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = f[i];
            step();
            ser_clk = 1'b1;
            step();
            model = {model[12:0], f[i]};
            if (pass_chk) begin
                chk(m_val == model[8:0] && n_sel == model[10:9], "R7", m_val, model[8:0]);
            end
            ser_clk = 1'b0;
            step();
        end
    endtask

    task automatic load_pulse();
        ser_load = 1'b1;
        step();
        ser_load = 1'b0;
        step();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        logic [13:0] f1, f2, f3, f4;
        logic [8:0]  held;
        rst = 1'b1; par_load_n = 1'b0; m_pins = 9'h123; n_pins = 2'd3;
        ser_clk = 1'b0; ser_dat = 1'b0; ser_load = 1'b0; mreset = 1'b0;
        mdiv_in = 1'b0; fout_in = 1'b0; model = '0;
        repeat (3) step();
        chk(m_val == 0 && n_sel == 0 && !test_out, "R11 reset state", m_val, 0);
        rst = 1'b0;
        step();
        chk(m_val == 9'h123 && n_sel == 2'd3, "R11 follow pins after reset", m_val, 9'h123);

        // Parallel vector table: R1, R2, R9
        fout_in = 1'b1; mdiv_in = 1'b1;
        foreach (VEC[i]) begin
            m_pins = VEC[i][15:7];
            n_pins = VEC[i][6:5];
            step();
            chk(m_val == VEC[i][15:7] && n_sel == VEC[i][6:5], "R1", m_val, VEC[i][15:7]);
            chk(div_ratio == VEC[i][4:0], "R9", div_ratio, VEC[i][4:0]);
            chk(!test_out, "R2", test_out, 0);
        end
        fout_in = 1'b0; mdiv_in = 1'b0;

        // Latch on rise of par_load_n: R3
        m_pins = 9'h0B7; n_pins = 2'd1;
        step();
        par_load_n = 1'b1;
        step();
        m_pins = 9'h1C4; n_pins = 2'd2;
        repeat (3) step();
        chk(m_val == 9'h0B7 && n_sel == 2'd1, "R3 latched", m_val, 9'h0B7);

        // Serial frame shifted with load low: R4, selector still 00 (R11, R8)
        f1 = frame(2'b01, 1'b0, 2'b10, 9'h11B);
        send(f1, 14, 1'b0);
        chk(m_val == 9'h0B7 && n_sel == 2'd1, "R4 shift keeps active", m_val, 9'h0B7);
        chk(!test_out, "R8 sel 00 low", test_out, 0);
        ser_load = 1'b1;
        step();
        chk(m_val == 9'h11B && n_sel == 2'd2 && div_ratio == 5'd8, "R5 commit", m_val, 9'h11B);
        chk(test_out == f1[13], "R8 sel 01 oldest bit", test_out, f1[13]);
        ser_load = 1'b0;
        step();
        // Walk the frame out through the test pin to confirm order: R4
        for (int k = 1; k <= 13; k++) begin
            ser_dat = 1'b0;
            step();
            ser_clk = 1'b1;
            step();
            model = {model[12:0], 1'b0};
            chk(test_out == f1[13-k], "R4 frame order", test_out, f1[13-k]);
            ser_clk = 1'b0;
            step();
        end
        chk(m_val == 9'h11B && n_sel == 2'd2, "R6 frozen after fall", m_val, 9'h11B);

        // Null bit set, selector 00: R5
        f2 = frame(2'b00, 1'b1, 2'b11, 9'h0F0);
        send(f2, 14, 1'b0);
        mdiv_in = 1'b1; fout_in = 1'b1;
        load_pulse();
        chk(m_val == 9'h0F0 && n_sel == 2'd3 && div_ratio == 5'd16, "R5 null ignored", m_val, 9'h0F0);
        chk(!test_out, "R8 sel 00 low with inputs high", test_out, 0);
        mdiv_in = 1'b0; fout_in = 1'b0;

        // Pass-through with load held high: R7
        ser_load = 1'b1;
        step();
        f3 = frame(2'b11, 1'b0, 2'b01, 9'h0C5);
        send(f3, 14, 1'b1);
        ser_load = 1'b0;
        step();
        chk(m_val == 9'h0C5 && n_sel == 2'd1 && div_ratio == 5'd4, "R7 final", m_val, 9'h0C5);
        fout_in = 1'b1;
        step();
        chk(test_out == 1'b1, "R8 sel 11 fout high", test_out, 1);
        fout_in = 1'b0;
        step();
        chk(test_out == 1'b0, "R8 sel 11 fout low", test_out, 0);
        send(frame(2'b00, 1'b0, 2'b00, 9'h001), 3, 1'b0);
        chk(m_val == 9'h0C5, "R6 shift after fall", m_val, 9'h0C5);

        // Selector 10
        f4 = frame(2'b10, 1'b0, 2'b00, 9'h00A);
        send(f4, 14, 1'b0);
        load_pulse();
        chk(div_ratio == 5'd2 && m_val == 9'h00A, "R9 serial ratio", div_ratio, 2);
        mdiv_in = 1'b1;
        step();
        chk(test_out == 1'b1, "R8 sel 10 mdiv high", test_out, 1);

        // Master reset: R10
        held = m_val;
        mreset = 1'b1;
        step();
        step();
        chk(div_clr == 1'b1, "R10 div_clr", div_clr, 1);
        chk(m_val == held && n_sel == 2'd0 && test_out == 1'b1, "R10 values kept", m_val, held);
        mreset = 1'b0;
        step();
        chk(div_clr == 1'b0, "R10 div_clr low", div_clr, 0);

        // Parallel mode ignores serial activity: R2, R12
        par_load_n = 1'b0; m_pins = 9'h033; n_pins = 2'd1;
        step();
        chk(!test_out, "R2 par low forces test low", test_out, 1'b0);
        ser_dat = 1'b1;
        ser_clk = 1'b1; step(); ser_clk = 1'b0; step();
        ser_load = 1'b1; step();
        ser_clk = 1'b1; step(); ser_clk = 1'b0; step();
        ser_load = 1'b0; step();
        chk(m_val == 9'h033 && n_sel == 2'd1, "R12 active unchanged", m_val, 9'h033);
        par_load_n = 1'b1;
        step();
        chk(test_out == 1'b1, "R12 selector kept", test_out, 1);
        chk(m_val == 9'h033, "R3 hold after serial-ignored", m_val, 9'h033);

        // Power-on reset clears the selector: R11
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        chk(!test_out && m_val == 0, "R11 selector cleared", test_out, 0);

        finish_run();
    end
endmodule